// File: doc/BRIEF.md
# Edge/Level Interrupt Aggregator with Vector Routing

This block collects up to 64 peripheral interrupt lines and drives a small set of parent interrupt outputs. Each line is detected either on its rising edge or by its level. Per line it keeps a pending bit, an in-service bit and the last sampled level. An 8-bit vector table chooses which parent output each line drives.

Dispatch is incremental. Each event looks at a set of changed lines and acts on only the lowest-numbered qualifying line in that set. That line's in-service bit is updated, and so is the parent output its vector selects. Input lines are sampled once per clock. When several lines change in the same cycle, their events are queued and handled one line per cycle in ascending order. Writing the mask replays assert and deassert events. Writing the clear register acknowledges edge lines.

Software reaches the block through a plain 32-bit register bus. Writes are a single-cycle strobe, and read data is combinational from the address. Each 64-bit register appears as a low word at its base and a high word at base+4. The vector and route tables are addressed one byte at a time. Auto-control and other unmapped words read as zero and ignore writes.

Top module: `pic_agg`

## Requirements
- R1: After reset these hold. Mask (0x020/0x024) reads all ones. Edge-select (0x040/0x044), status (0x080/0x084) and polarity (0x0A0/0x0A4) read zero. Every route entry (byte at 0x100+n) reads 1. Every vector entry (byte at 0x200+n) reads 0. All parent outputs are low.
- R2: The ID low word (0x000) reads 0x0000A5C1. The ID high word (0x004) returns the version (default 0x0001) in bits 15:0 and NUM_LINES-1 in bits 31:16.
- R3: A level line (edge-select bit 0) has pending equal to its sampled input. When the line is unmasked and its input rises, its in-service bit sets and the output selected by its vector goes high. When the input falls, both clear.
- R4: An edge line (edge-select bit 1) sets pending only when its input is sampled high after a low sample. A falling input leaves pending, in-service and the parent output unchanged.
- R5: Writing data D to the clear word (0x060 low, 0x064 high) acts only on lines that are both set in D and edge-configured. For those lines, pending is cleared, the lowest such line in service drops its vector's output, and in-service is cleared. Level lines named in D are untouched.
- R6: A mask bit that goes from 1 to 0 in a mask write replays an assert event. The lowest newly unmasked line that is pending sets in-service and raises its output, in the same cycle as the write.
- R7: A mask bit that goes from 0 to 1 replays a deassert event, which acts only on a line that is in service and no longer pending. A line masked while still pending keeps its output high. Status reads return in-service & ~mask, so a masked line reads as 0.
- R8: An input change sampled at clock edge k is dispatched at edge k+1, at the earliest. When several lines change together, the lowest index is dispatched first, then one further line per clock. In-service never changes by more than one bit per cycle without a bus write.
- R9: A vector value v below NUM_OUTS selects parent output v. A value at or above NUM_OUTS drives no output, but the line's in-service bit is still set.
- R10: A 32-bit write to either half of a 64-bit register replaces only that half and keeps the other half.
- R11: The route and vector tables hold 64 bytes each, written from wdata[7:0]. Table indices 64..255 read as zero and ignore writes. Route entries are stored and read back only.
- R12: Writing the status word replaces that half of the in-service register directly and does not change any parent output.
- R13: Polarity is stored and read back per half and has no effect on detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Peripheral interrupt lines, sampled every clock |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address of the register or table entry |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| parent_irq | output | NUM_OUTS | Parent interrupt outputs selected through the vector table |

## Verification
The hardest situation to reach from the ports is a line that is pending and in service while masked, followed by a mask write that must leave its output alone. A deassert replay must only act on lines that are no longer pending, so this case shows whether the design applies that rule. The bench reaches it in steps. It raises a level line while masked and checks that the output stays low. It then unmasks the line, which replays an assert. It masks the line again while the input is still high, and checks that the output holds while the status read shows zero. A second hard-to-reach case is the one-line-per-cycle ordering. The bench drives two lines high on the same edge and samples the outputs between the two dispatch edges.

// File: rtl/pic_agg_pkg.sv
package pic_agg_pkg;
  localparam int REG_W     = 64;
  localparam int TBL_DEPTH = 64;
  localparam int BUS_W     = 32;

  localparam logic [31:0] PIC_ID_CODE = 32'h0000_A5C1;

  localparam logic [11:0] A_ID     = 12'h000;
  localparam logic [11:0] A_MASK   = 12'h020;
  localparam logic [11:0] A_EDGE   = 12'h040;
  localparam logic [11:0] A_CLEAR  = 12'h060;
  localparam logic [11:0] A_STATUS = 12'h080;
  localparam logic [11:0] A_POL    = 12'h0A0;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ID, SEL_MASK, SEL_EDGE, SEL_CLEAR,
    SEL_STATUS, SEL_POL, SEL_ROUTE, SEL_VEC
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [11:0] a);
    reg_sel_e s;
    s = SEL_NONE;
    if (a[11:8] == 4'h1)      s = SEL_ROUTE;
    else if (a[11:8] == 4'h2) s = SEL_VEC;
    else begin
      case (a[11:3])
        A_ID[11:3]:     s = SEL_ID;
        A_MASK[11:3]:   s = SEL_MASK;
        A_EDGE[11:3]:   s = SEL_EDGE;
        A_CLEAR[11:3]:  s = SEL_CLEAR;
        A_STATUS[11:3]: s = SEL_STATUS;
        A_POL[11:3]:    s = SEL_POL;
        default:        s = SEL_NONE;
      endcase
    end
    return s;
  endfunction

  function automatic logic [REG_W-1:0] merge_half(input logic [REG_W-1:0] old,
                                                  input logic [BUS_W-1:0] d,
                                                  input logic hi);
    return hi ? {d, old[31:0]} : {old[63:32], d};
  endfunction

  function automatic logic [BUS_W-1:0] read_half(input logic [REG_W-1:0] v,
                                                 input logic hi);
    return hi ? v[63:32] : v[31:0];
  endfunction

  function automatic logic [REG_W-1:0] place_half(input logic [BUS_W-1:0] d,
                                                  input logic hi);
    return hi ? {d, 32'h0} : {32'h0, d};
  endfunction
endpackage

// File: rtl/pic_line_detect.sv
module pic_line_detect #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lines_in,
  output logic [WIDTH-1:0] last_lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] changed
);
  assign rise    = lines_in & ~last_lvl;
  assign changed = lines_in ^ last_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_lvl <= '0;
    else        last_lvl <= lines_in;
  end
endmodule

// File: rtl/pic_low_pick.sv
module pic_low_pick #(
  parameter int WIDTH = 64,
  parameter int IW    = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] req,
  output logic             hit,
  output logic [IW-1:0]    idx
);
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pic_byte_table.sv
module pic_byte_table #(
  parameter int         DEPTH   = 64,
  parameter int         IW      = $clog2(DEPTH),
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IW-1:0]         wr_idx,
  input  logic [7:0]            wr_data,
  output logic [DEPTH-1:0][7:0] entries
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) entries[i] <= RST_VAL;
    end else if (wr_en) begin
      entries[wr_idx] <= wr_data;
    end
  end
endmodule

// File: rtl/pic_agg.sv
module pic_agg
  import pic_agg_pkg::*;
#(
  parameter int          NUM_LINES  = 64,
  parameter int          NUM_OUTS   = 16,
  parameter logic [15:0] ID_VERSION = 16'h0001
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 bus_wr,
  input  logic [11:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_OUTS-1:0]  parent_irq
);
  localparam int LIW     = $clog2(TBL_DEPTH);
  localparam int NPICK   = 4;
  localparam int PK_DISP = 0;
  localparam int PK_UP   = 1;
  localparam int PK_DN   = 2;
  localparam int PK_CLR  = 3;

  logic [REG_W-1:0] mask_q, edge_q, pend_q, isr_q, pol_q, evq_q;
  logic [REG_W-1:0] mask_n, edge_n, pend_n, isr_n, pol_n, evq_n;
  logic [NUM_OUTS-1:0] out_q, out_n;

  logic [NUM_LINES-1:0] last_l, rise_l, chg_l;
  logic [REG_W-1:0] in_ext, last_x, rise_x, chg_x;

  always_comb begin
    in_ext = '0; last_x = '0; rise_x = '0; chg_x = '0;
    in_ext[NUM_LINES-1:0] = irq_in;
    last_x[NUM_LINES-1:0] = last_l;
    rise_x[NUM_LINES-1:0] = rise_l;
    chg_x[NUM_LINES-1:0]  = chg_l;
  end

  pic_line_detect #(.WIDTH(NUM_LINES)) u_detect (
    .clk(clk), .rst_n(rst_n), .lines_in(irq_in),
    .last_lvl(last_l), .rise(rise_l), .changed(chg_l)
  );

  // bus decode
  reg_sel_e sel;
  logic     hi, tidx_ok;
  assign sel     = decode_addr(bus_addr);
  assign hi      = bus_addr[2];
  assign tidx_ok = (bus_addr[7:6] == 2'b00);

  logic [TBL_DEPTH-1:0][7:0] route_tbl, vec_tbl;
  logic route_we, vec_we;
  assign route_we = bus_wr && (sel == SEL_ROUTE) && tidx_ok;
  assign vec_we   = bus_wr && (sel == SEL_VEC) && tidx_ok;

  pic_byte_table #(.DEPTH(TBL_DEPTH), .RST_VAL(8'h01)) u_route (
    .clk(clk), .rst_n(rst_n), .wr_en(route_we), .wr_idx(bus_addr[LIW-1:0]),
    .wr_data(bus_wdata[7:0]), .entries(route_tbl)
  );
  pic_byte_table #(.DEPTH(TBL_DEPTH), .RST_VAL(8'h00)) u_vec (
    .clk(clk), .rst_n(rst_n), .wr_en(vec_we), .wr_idx(bus_addr[LIW-1:0]),
    .wr_data(bus_wdata[7:0]), .entries(vec_tbl)
  );

  // event sets presented to the lowest-bit pickers
  logic [REG_W-1:0] mask_new, up_set, dn_set, clr_eff;
  assign mask_new = (bus_wr && sel == SEL_MASK) ? merge_half(mask_q, bus_wdata, hi) : mask_q;
  assign up_set   = mask_q & ~mask_new;
  assign dn_set   = ~mask_q & mask_new;
  assign clr_eff  = (bus_wr && sel == SEL_CLEAR) ? (place_half(bus_wdata, hi) & edge_q) : '0;

  logic [NPICK-1:0][REG_W-1:0] pick_req;
  logic [NPICK-1:0]            pick_hit;
  logic [NPICK-1:0][LIW-1:0]   pick_idx;

  assign pick_req[PK_DISP] = bus_wr ? '0 : evq_q;
  assign pick_req[PK_UP]   = up_set & pend_q & ~mask_new;
  assign pick_req[PK_DN]   = dn_set & isr_q & ~pend_q;
  assign pick_req[PK_CLR]  = clr_eff & isr_q;

  for (genvar g = 0; g < NPICK; g++) begin : g_pick
    pic_low_pick #(.WIDTH(REG_W), .IW(LIW)) u_pick (
      .req(pick_req[g]), .hit(pick_hit[g]), .idx(pick_idx[g])
    );
  end

  function automatic logic [NUM_OUTS-1:0] vec_dec(input logic [7:0] v);
    logic [NUM_OUTS-1:0] d;
    d = '0;
    for (int o = 0; o < NUM_OUTS; o++) begin
      if (v == 8'(o)) d[o] = 1'b1;
    end
    return d;
  endfunction

  // next-state: inputs, queued dispatch, then bus-side replays in fixed order
  always_comb begin
    logic [LIW-1:0] p;
    mask_n = mask_new;
    edge_n = (bus_wr && sel == SEL_EDGE) ? merge_half(edge_q, bus_wdata, hi) : edge_q;
    pol_n  = (bus_wr && sel == SEL_POL)  ? merge_half(pol_q, bus_wdata, hi)  : pol_q;
    pend_n = ((edge_q & (pend_q | rise_x)) | (~edge_q & in_ext)) & ~clr_eff;
    evq_n  = evq_q | chg_x;
    isr_n  = isr_q;
    out_n  = out_q;

    p = pick_idx[PK_DISP];
    if (pick_hit[PK_DISP]) begin
      evq_n[p] = chg_x[p];
      if (last_x[p]) begin
        if (pend_q[p] && !mask_q[p]) begin
          isr_n[p] = 1'b1;
          out_n    = out_n | vec_dec(vec_tbl[p]);
        end
      end else if (isr_q[p] && !pend_q[p]) begin
        isr_n[p] = 1'b0;
        out_n    = out_n & ~vec_dec(vec_tbl[p]);
      end
    end

    if (pick_hit[PK_UP]) begin
      isr_n[pick_idx[PK_UP]] = 1'b1;
      out_n = out_n | vec_dec(vec_tbl[pick_idx[PK_UP]]);
    end
    if (pick_hit[PK_DN]) begin
      isr_n[pick_idx[PK_DN]] = 1'b0;
      out_n = out_n & ~vec_dec(vec_tbl[pick_idx[PK_DN]]);
    end
    if (pick_hit[PK_CLR]) begin
      out_n = out_n & ~vec_dec(vec_tbl[pick_idx[PK_CLR]]);
    end
    isr_n = isr_n & ~clr_eff;

    if (bus_wr && sel == SEL_STATUS) isr_n = merge_half(isr_q, bus_wdata, hi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      edge_q <= '0;
      pend_q <= '0;
      isr_q  <= '0;
      pol_q  <= '0;
      evq_q  <= '0;
      out_q  <= '0;
    end else begin
      mask_q <= mask_n;
      edge_q <= edge_n;
      pend_q <= pend_n;
      isr_q  <= isr_n;
      pol_q  <= pol_n;
      evq_q  <= evq_n;
      out_q  <= out_n;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_ID:     bus_rdata = hi ? {16'(NUM_LINES - 1), ID_VERSION} : PIC_ID_CODE;
      SEL_MASK:   bus_rdata = read_half(mask_q, hi);
      SEL_EDGE:   bus_rdata = read_half(edge_q, hi);
      SEL_STATUS: bus_rdata = read_half(isr_q & ~mask_q, hi);
      SEL_POL:    bus_rdata = read_half(pol_q, hi);
      SEL_ROUTE:  if (tidx_ok) bus_rdata = {24'h0, route_tbl[bus_addr[LIW-1:0]]};
      SEL_VEC:    if (tidx_ok) bus_rdata = {24'h0, vec_tbl[bus_addr[LIW-1:0]]};
      default:    bus_rdata = '0;
    endcase
  end

  assign parent_irq = out_q;
endmodule

// File: rtl/pic_agg_checker.sv
module pic_agg_checker #(
  parameter int NUM_LINES = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [63:0] lines,
  input logic [63:0] pend,
  input logic [63:0] isr,
  input logic [63:0] mask,
  input logic [63:0] edge_sel
);
  localparam logic [63:0] LINE_MASK =
    (NUM_LINES >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << NUM_LINES) - 64'd1);

  AST_ISR_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bus_wr)) |-> ($countones(isr ^ $past(isr)) <= 1))
    else $error("in-service changed by more than one line"); // R8

  AST_EDGE_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bus_wr)) |-> (($past(pend & edge_sel) & ~pend) == 64'h0))
    else $error("edge pending dropped without a bus write"); // R4

  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bus_wr)) |-> (((pend ^ $past(lines)) & ~edge_sel & LINE_MASK) == 64'h0))
    else $error("level pending does not follow input"); // R3

  AST_MASKED_NO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bus_wr)) |-> ((isr & ~$past(isr) & mask) == 64'h0))
    else $error("masked line entered service"); // R6
endmodule

bind pic_agg pic_agg_checker #(.NUM_LINES(NUM_LINES)) u_pic_agg_checker (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .lines(in_ext),
  .pend(pend_q), .isr(isr_q), .mask(mask_q), .edge_sel(edge_q)
);

// File: tb/pic_agg_bench.sv
module pic_agg_bench;
  localparam int NL = 64;
  localparam int NO = 16;

  localparam logic [11:0] R_ID_LO = 12'h000, R_ID_HI = 12'h004;
  localparam logic [11:0] R_MASK_LO = 12'h020, R_MASK_HI = 12'h024;
  localparam logic [11:0] R_EDGE_LO = 12'h040;
  localparam logic [11:0] R_CLR_LO = 12'h060;
  localparam logic [11:0] R_STAT_LO = 12'h080, R_STAT_HI = 12'h084;
  localparam logic [11:0] R_POL_LO = 12'h0A0, R_POL_HI = 12'h0A4;
  localparam logic [11:0] R_ROUTE = 12'h100, R_VEC = 12'h200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NL-1:0] irq_in = '0;
  logic bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NO-1:0] parent_irq;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pic_agg #(.NUM_LINES(NL), .NUM_OUTS(NO)) u_pic_agg (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .parent_irq(parent_irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(R_MASK_LO, v); check("R1 mask lo", v, 32'hFFFF_FFFF);
    rd(R_MASK_HI, v); check("R1 mask hi", v, 32'hFFFF_FFFF);
    rd(R_EDGE_LO, v); check("R1 edge lo", v, 32'h0);
    rd(R_STAT_LO, v); check("R1 status lo", v, 32'h0);
    rd(R_POL_HI, v);  check("R1 polarity hi", v, 32'h0);
    rd(R_ROUTE + 12'd5, v); check("R1 route 5", v, 32'h1);
    rd(R_ROUTE + 12'd63, v); check("R1 route 63", v, 32'h1);
    rd(R_VEC + 12'd5, v); check("R1 vector 5", v, 32'h0);
    check("R1 outputs", 32'(parent_irq), 32'h0);
    rd(R_ID_LO, v); check("R2 id lo", v, 32'h0000_A5C1);
    rd(R_ID_HI, v); check("R2 id hi", v, 32'h003F_0001);
  endtask

  task automatic t_level;
    logic [31:0] v;
    wr(R_VEC + 12'd3, 32'd2);
    wr(R_MASK_LO, 32'hFFFF_FFF7);
    irq_in[3] = 1'b1; settle(3);
    check("R3 level assert out", 32'(parent_irq), 32'h4);
    rd(R_STAT_LO, v); check("R3 level status", v, 32'h8);
    irq_in[3] = 1'b0; settle(3);
    check("R3 level drop out", 32'(parent_irq), 32'h0);
    rd(R_STAT_LO, v); check("R3 level drop status", v, 32'h0);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    wr(R_EDGE_LO, 32'h20);
    wr(R_VEC + 12'd5, 32'd4);
    wr(R_MASK_LO, 32'hFFFF_FFD7);
    irq_in[5] = 1'b1; settle(1);
    irq_in[5] = 1'b0; settle(4);
    check("R4 edge held after fall", 32'(parent_irq), 32'h10);
    rd(R_STAT_LO, v); check("R4 edge status held", v, 32'h20);
    wr(R_CLR_LO, 32'h20);
    check("R5 clear drops out", 32'(parent_irq), 32'h0);
    rd(R_STAT_LO, v); check("R5 clear status", v, 32'h0);
  endtask

  task automatic t_clear_level;
    logic [31:0] v;
    irq_in[3] = 1'b1; settle(3);
    wr(R_CLR_LO, 32'h8);
    check("R5 clear ignores level out", 32'(parent_irq), 32'h4);
    rd(R_STAT_LO, v); check("R5 clear ignores level status", v, 32'h8);
    irq_in[3] = 1'b0; settle(3);
    check("R5 level drop after clear", 32'(parent_irq), 32'h0);
  endtask

  task automatic t_mask_replay;
    logic [31:0] v;
    wr(R_MASK_LO, 32'hFFFF_FFFF);
    irq_in[3] = 1'b1; settle(3);
    check("R6 masked no out", 32'(parent_irq), 32'h0);
    wr(R_MASK_LO, 32'hFFFF_FFF7);
    check("R6 unmask replays assert", 32'(parent_irq), 32'h4);
    wr(R_MASK_LO, 32'hFFFF_FFFF);
    check("R7 remask while pending keeps out", 32'(parent_irq), 32'h4);
    rd(R_STAT_LO, v); check("R7 status hides masked", v, 32'h0);
    irq_in[3] = 1'b0; settle(3);
    check("R7 drop clears out", 32'(parent_irq), 32'h0);
  endtask

  task automatic t_order;
    wr(R_VEC + 12'd2, 32'd1);
    wr(R_MASK_LO, 32'hFFFF_FFF9);
    irq_in[1] = 1'b1; irq_in[2] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R8 lowest first", 32'(parent_irq[1:0]), 32'h1);
    @(posedge clk); #1;
    check("R8 next line one cycle later", 32'(parent_irq[1:0]), 32'h3);
    @(negedge clk);
    irq_in[1] = 1'b0; irq_in[2] = 1'b0; settle(4);
    check("R8 both dropped", 32'(parent_irq), 32'h0);
  endtask

  task automatic t_vec_range;
    logic [31:0] v;
    wr(R_VEC + 12'd7, 32'd200);
    wr(R_MASK_LO, 32'hFFFF_FF7F);
    irq_in[7] = 1'b1; settle(3);
    check("R9 out-of-range vector drives none", 32'(parent_irq), 32'h0);
    rd(R_STAT_LO, v); check("R9 in-service still set", v, 32'h80);
    irq_in[7] = 1'b0; settle(3);
  endtask

  task automatic t_half;
    logic [31:0] v;
    wr(R_VEC + 12'd40, 32'd3);
    wr(R_MASK_HI, 32'hFFFF_FEFF);
    rd(R_MASK_LO, v); check("R10 low half kept", v, 32'hFFFF_FF7F);
    rd(R_MASK_HI, v); check("R10 high half written", v, 32'hFFFF_FEFF);
    irq_in[40] = 1'b1; settle(3);
    check("R9 vector 3 out", 32'(parent_irq), 32'h8);
    rd(R_STAT_HI, v); check("R10 status hi", v, 32'h100);
    irq_in[40] = 1'b0; settle(3);
    check("R3 high line drop", 32'(parent_irq), 32'h0);
  endtask

  task automatic t_status_write;
    logic [31:0] v;
    wr(R_STAT_LO, 32'h10);
    rd(R_STAT_LO, v); check("R12 masked written bit hidden", v, 32'h0);
    wr(R_MASK_LO, 32'hFFFF_FF6F);
    rd(R_STAT_LO, v); check("R12 status write visible", v, 32'h10);
    check("R12 outputs untouched", 32'(parent_irq), 32'h0);
    wr(R_STAT_LO, 32'h0);
    rd(R_STAT_LO, v); check("R12 status write clears", v, 32'h0);
  endtask

  task automatic t_tables;
    logic [31:0] v;
    wr(R_ROUTE + 12'd70, 32'h55);
    rd(R_ROUTE + 12'd70, v); check("R11 route beyond 63 reads zero", v, 32'h0);
    rd(R_ROUTE + 12'd6, v);  check("R11 aliased entry untouched", v, 32'h1);
    wr(R_ROUTE + 12'd10, 32'h15A);
    rd(R_ROUTE + 12'd10, v); check("R11 route byte write", v, 32'h5A);
    wr(R_VEC + 12'd100, 32'h9);
    rd(R_VEC + 12'd36, v);   check("R11 vector alias untouched", v, 32'h0);
  endtask

  task automatic t_polarity;
    logic [31:0] v;
    wr(R_POL_HI, 32'hDEAD_0001);
    rd(R_POL_HI, v); check("R13 polarity hi readback", v, 32'hDEAD_0001);
    rd(R_POL_LO, v); check("R13 polarity lo kept", v, 32'h0);
    wr(R_POL_LO, 32'hFFFF_FFFF);
    wr(R_MASK_LO, 32'hFFFF_FFF7);
    irq_in[3] = 1'b1; settle(3);
    check("R13 polarity no effect", 32'(parent_irq), 32'h4);
    irq_in[3] = 1'b0; settle(3);
    check("R13 polarity no effect drop", 32'(parent_irq), 32'h0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle(1);
    t_reset();
    t_level();
    t_edge();
    t_clear_level();
    t_mask_replay();
    t_order();
    t_vec_range();
    t_half();
    t_status_write();
    t_tables();
    t_polarity();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule